// File: doc/BRIEF.md
# Two-way set-associative word cache

This unit sits between a processor request port and a slower word memory. It holds a configurable number of sets, and each set has two ways. Every way stores one 32-bit word, a tag and a valid flag, and every set keeps one replacement bit. On each access the set is chosen from the address bits just above the byte offset. Both tags of that set are compared at the same time, and a multiplexer driven by the comparison picks the word to return.

A read hit answers in the next cycle without any memory traffic. A read miss holds a refill request on the memory port until the word arrives. That word is then installed in a victim way and returned. An empty way is chosen as victim before a full one. Stores are written through to memory every time. A store hit also updates the cached word, and a store miss leaves the cache untouched (no allocation). Two counters tally hits and misses, so that the miss count of a reference string can be read directly.

Top module: `two_way_cache`

## Requirements
- R1: After reset every way is invalid and every replacement bit is cleared. hit_count and miss_count read 0, resp_valid and mem_rd_req are low, and req_ready is high.
- R2: The set index is address bits [2 +: log2(SETS)], and the tag is all the bits above the index. The two low byte-offset bits are ignored for lookup, so any byte address inside a cached word hits.
- R3: A read that finds a valid way with a matching tag raises resp_valid with resp_hit=1 in the cycle after acceptance. resp_rdata carries that way's word, and no refill is requested.
- R4: On a read miss, resp_valid stays low and req_ready drops. Starting the cycle after acceptance, mem_rd_req is held high with mem_addr set to the word-aligned address (offset bits zero) until mem_rd_valid. In the cycle after mem_rd_valid, resp_valid rises with resp_hit=0 and resp_rdata equal to the refilled word.
- R5: On a refill, an invalid way is chosen first, checking way 0 before way 1. When both ways are valid, the way named by the set's replacement bit is overwritten.
- R6: Every read hit, read refill and write hit marks the referenced way as most recent, which makes the other way of that set the next victim.
- R7: Every accepted write raises mem_wr_req for exactly the following cycle, with the aligned mem_addr and the store data on mem_wdata. resp_valid rises in that same cycle, with resp_hit showing whether the store hit. On a hit the cached word takes the store data.
- R8: A write miss installs nothing and leaves both ways and the replacement bit of the set unchanged, so a later read of that address still misses.
- R9: Each accepted request increments exactly one of hit_count or miss_count, in the cycle after acceptance.
- R10: With SETS=2, starting from reset, reading words 0,4,0,4,0,4,0,4 (byte addresses 0 and 16) gives exactly 2 misses and 6 hits.
- R11: A new request is accepted only while req_ready is high. req_ready is low from a read miss until its refill has been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Request accepted this cycle when high |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Response was a hit |
| resp_rdata | output | DATA_W | Load data |
| mem_rd_req | output | 1 | Refill request, held until answered |
| mem_wr_req | output | 1 | Write-through strobe |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_wdata | output | DATA_W | Write-through data |
| mem_rd_valid | input | 1 | Refill data present |
| mem_rd_data | input | DATA_W | Refill word |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
A wrong tag, valid flag or replacement bit shows up as a wrong resp_hit one cycle after the access that depends on it. An extra or missing mem_rd_req appears on the same cycle, and the counters drift at once. A corrupted cached word only shows on the next read hit of that word, as resp_rdata differing from the memory contents. A wrong victim choice shows up later, as an unexpected miss on whichever word was wrongly evicted. A long reference stream with writes mixed in, run on a two-set build, makes every such fault reach the ports within a few accesses.

// File: rtl/two_way_cache.sv
module two_way_cache #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 64,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int OFF_W = 2;
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  logic [TAG_W-1:0]  tag_q  [2][SETS];
  logic [DATA_W-1:0] data_q [2][SETS];
  logic [SETS-1:0]   vld_q  [2];
  logic [SETS-1:0]   lru_q;
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  wire              fire     = req_valid && !busy_q;
  wire [IDX_W-1:0]  idx      = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag      = req_addr[ADDR_W-1 -: TAG_W];
  wire              hit0     = vld_q[0][idx] && (tag_q[0][idx] == tag);
  wire              hit1     = vld_q[1][idx] && (tag_q[1][idx] == tag);
  wire              hit      = hit0 || hit1;
  wire [DATA_W-1:0] hit_data = hit1 ? data_q[1][idx] : data_q[0][idx];

  wire [IDX_W-1:0]  fidx     = addr_q[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  ftag     = addr_q[ADDR_W-1 -: TAG_W];
  wire              victim   = !vld_q[0][fidx] ? 1'b0 :
                               !vld_q[1][fidx] ? 1'b1 : lru_q[fidx];
  wire              fill     = busy_q && mem_rd_valid;

  assign req_ready  = !busy_q;
  assign mem_rd_req = busy_q;
  assign mem_addr   = addr_q;
  assign mem_wdata  = wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      vld_q[0]   <= '0;
      vld_q[1]   <= '0;
      lru_q      <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      mem_wr_req <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      resp_valid <= 1'b0;
      mem_wr_req <= 1'b0;
      if (fire) begin
        addr_q  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        wdata_q <= req_wdata;
        if (hit) hit_count  <= hit_count + 1'b1;
        else     miss_count <= miss_count + 1'b1;
        if (req_write) begin
          mem_wr_req <= 1'b1;
          resp_valid <= 1'b1;
          resp_hit   <= hit;
          resp_rdata <= req_wdata;
          if (hit) lru_q[idx] <= !hit1;
        end else if (hit) begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          resp_rdata <= hit_data;
          lru_q[idx] <= !hit1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (fill) begin
        busy_q              <= 1'b0;
        vld_q[victim][fidx] <= 1'b1;
        lru_q[fidx]         <= !victim;
        resp_valid          <= 1'b1;
        resp_hit            <= 1'b0;
        resp_rdata          <= mem_rd_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fire && req_write && hit)
      data_q[hit1][idx] <= req_wdata;
    else if (rst_n && !fire && fill) begin
      data_q[victim][fidx] <= mem_rd_data;
      tag_q[victim][fidx]  <= ftag;
    end
  end
endmodule

module two_way_cache_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic [DATA_W-1:0] resp_rdata,
  input logic              mem_rd_req,
  input logic              mem_wr_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd_valid,
  input logic [DATA_W-1:0] mem_rd_data,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count
);
  assert_refill_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && !mem_rd_valid |=> mem_rd_req && $stable(mem_addr));

  assert_fill_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req && mem_rd_valid |=> resp_valid && !resp_hit && resp_rdata == $past(mem_rd_data));

  assert_write_through_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> $past(req_valid && req_ready && req_write));

  assert_hit_counted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_hit |-> hit_count == CNT_W'($past(hit_count) + 1'b1));

  assert_one_counter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> ((hit_count != $past(hit_count)) != (miss_count != $past(miss_count))));

  assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> $stable(hit_count) && $stable(miss_count));
endmodule

bind two_way_cache two_way_cache_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_rdata(resp_rdata), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
  .mem_addr(mem_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
  .hit_count(hit_count), .miss_count(miss_count));

// File: tb/two_way_cache_bench.sv
module two_way_cache_bench;
  localparam int AW = 32, DW = 32, CW = 16, NS = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, resp_valid, resp_hit, mem_rd_req, mem_wr_req;
  logic [DW-1:0] resp_rdata, mem_wdata;
  logic [AW-1:0] mem_addr;
  logic          mem_rd_valid = 1'b0;
  logic [DW-1:0] mem_rd_data = '0;
  logic [CW-1:0] hit_count, miss_count;

  always #2 clk = ~clk;

  two_way_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(NS), .CNT_W(CW)) u_two_way_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .hit_count(hit_count), .miss_count(miss_count));

  logic [DW-1:0] mem [64];
  int lat = 0;
  always @(negedge clk) begin
    if (mem_rd_req && !mem_rd_valid) begin
      if (lat == 2) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem[mem_addr[7:2]];
        lat = 0;
      end else lat = lat + 1;
    end else mem_rd_valid = 1'b0;
  end

  int  vectors = 0, errors = 0;
  bit  mv [NS][2];
  int  mt [NS][2];
  bit  ml [NS];
  int  ehit = 0, emiss = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int w, input int boff, input logic [DW-1:0] wd, input string rq);
    int s, t, vw, n;
    bit h0, h1, h;
    s  = w % NS;
    t  = w / NS;
    h0 = mv[s][0] && mt[s][0] == t;
    h1 = mv[s][1] && mt[s][1] == t;
    h  = h0 || h1;
    @(negedge clk);
    chk(req_ready == 1'b1, rq, "req_ready before request (R11)", req_ready, 1);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(w * 4 + boff); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (h) ehit++; else emiss++;
    if (wr) begin
      chk(mem_wr_req == 1'b1, rq, "mem_wr_req (R7)", mem_wr_req, 1);
      chk(mem_addr == AW'(w * 4), rq, "write mem_addr (R7)", mem_addr, w * 4);
      chk(mem_wdata == wd, rq, "mem_wdata (R7)", mem_wdata, wd);
      chk(resp_valid && resp_hit == h, rq, "write resp_hit (R7 R8)", resp_hit, h);
      mem[w] = wd;
      if (h) ml[s] = !h1;
    end else if (h) begin
      chk(resp_valid && resp_hit, rq, "read hit (R3)", resp_hit, 1);
      chk(resp_rdata == mem[w], rq, "hit data (R3)", resp_rdata, mem[w]);
      chk(mem_rd_req == 1'b0, rq, "no refill on hit (R3)", mem_rd_req, 0);
      ml[s] = !h1;
    end else begin
      chk(!resp_valid && mem_rd_req, rq, "refill request on miss (R4)", mem_rd_req, 1);
      chk(req_ready == 1'b0, rq, "busy during refill (R11)", req_ready, 0);
      chk(mem_addr == AW'(w * 4), rq, "refill mem_addr aligned (R4 R2)", mem_addr, w * 4);
      n = 0;
      while (!resp_valid && n < 20) begin @(negedge clk); n++; end
      chk(resp_valid && !resp_hit, rq, "refill response (R4)", resp_hit, 0);
      chk(resp_rdata == mem[w], rq, "refill data (R4)", resp_rdata, mem[w]);
      vw = !mv[s][0] ? 0 : !mv[s][1] ? 1 : int'(ml[s]);
      mv[s][vw] = 1'b1; mt[s][vw] = t; ml[s] = (vw == 0);
    end
    chk(hit_count == CW'(ehit), rq, "hit_count (R9)", hit_count, ehit);
    chk(miss_count == CW'(emiss), rq, "miss_count (R9)", miss_count, emiss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int x;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 + i * 32'h0101;
    for (int s = 0; s < NS; s++) begin mv[s][0] = 0; mv[s][1] = 0; ml[s] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !resp_valid && !mem_rd_req, "R1", "idle after reset", {req_ready, resp_valid, mem_rd_req}, 3'b100);
    chk(hit_count == 0 && miss_count == 0, "R1", "counters after reset", {hit_count, miss_count}, 0);

    for (int i = 0; i < 8; i++) access(1'b0, (i % 2) * 4, 0, '0, "R10 R1");
    chk(miss_count == 2, "R10", "misses for 0,4 string", miss_count, 2);
    chk(hit_count == 6, "R10", "hits for 0,4 string", hit_count, 6);

    access(1'b0, 8, 0, '0, "R5 evict older");
    access(1'b0, 4, 0, '0, "R5 R6 survivor hits");
    access(1'b0, 0, 0, '0, "R5 evicted word misses");
    access(1'b0, 4, 3, '0, "R2 byte offset ignored");
    access(1'b0, 5, 1, '0, "R2 other set");
    access(1'b1, 12, 0, 32'h1234_5678, "R8 write miss");
    access(1'b0, 0, 0, '0, "R8 set untouched");
    access(1'b0, 4, 0, '0, "R8 set untouched");
    access(1'b0, 12, 0, '0, "R8 no allocate");
    access(1'b1, 12, 2, 32'hCAFE_0001, "R7 write hit");
    access(1'b0, 12, 0, '0, "R7 updated word");

    x = 32'h1357;
    for (int i = 0; i < 800; i++) begin
      x = (x * 1103515245 + 12345) & 32'h7FFF_FFFF;
      access(((x >> 9) % 4) == 0, (x >> 3) % 6, (x >> 13) % 4, DW'(x), "R3 R4 R5 R6 R7 R8 sweep");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule